// File: doc/BRIEF.md
# Character Display Bus Master with Busy-Flag Polling

This block drives a character display controller over a parallel bus with a single read/write direction line. It also drives a register-select line, which picks the instruction register or the data register, and an active-high enable strobe. A host hands it one byte at a time on a valid/ready handshake, together with a flag that says whether the byte is an instruction or display data. The block then produces enable pulses whose setup, high width, low width, hold and full cycle come from parameters counted in clock cycles. The defaults assume a 100 MHz clock.

The bus can be used at full byte width or in a narrow mode that uses only the upper four data lines. In the narrow mode each byte goes out as two pulses, with the high nibble first. After every byte the block reads the status register and looks at the busy flag on bit 7. It repeats that read until the flag clears, and only then does it take the next byte. In the narrow mode each status read is also two pulses, and only the first nibble carries the flag. If the flag stays set for a parameterised number of status reads, the block stops polling and raises an error output. The data bus appears as a separate output value, output enable and input. Only bit 7 of the input is ever sampled, so only that line is brought in.

Top module: `charlcd_busmaster`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are: `lcd_e`=0, `db_oe`=0, `in_ready`=1 and `timeout_err`=0.
- R2: During the write pulses for a byte, `lcd_rs` equals the `in_rs` value captured with that byte (0 = instruction register, 1 = data register).
- R3: In full-width mode (`mode4`=0), a byte is written with exactly one enable pulse. During that pulse `lcd_rw`=0, `db_oe`=1 and `db_out[7:0]` holds the byte when `lcd_e` falls.
- R4: In narrow mode (`mode4`=1), a byte is written with exactly two pulses. The first carries byte bits 7..4 on `db_out[7:4]` and the second carries bits 3..0 on `db_out[7:4]`. `db_out[3:0]` is 0 on both pulses.
- R5: `lcd_e` stays high for at least 140 ns and low for at least 140 ns. Write data on `db_out` is stable for at least 80 ns before `lcd_e` falls and does not change while `lcd_e` is high.
- R6: `lcd_rs` and `lcd_rw` are stable for at least 40 ns before `lcd_e` rises. They do not change while `lcd_e` is high and are held at least 10 ns after it falls. Write data is also held at least 10 ns after the fall.
- R7: From one rising edge of `lcd_e` to the next is at least 500 ns after a write pulse and at least 1000 ns after a read pulse.
- R8: After each byte, the block performs status reads (`lcd_rs`=0, `lcd_rw`=1). It repeats them while bit 7 is 1 and finishes on the first read with bit 7 = 0. Bit 7 is sampled on `db_in_msb` in the last cycle before `lcd_e` falls. No write pulse occurs while the display reports busy.
- R9: In narrow mode, each status read consists of two pulses. Only the first pulse's `db_in_msb` is the flag; the value on the second pulse is ignored.
- R10: `db_oe` and `lcd_rw` are never both 1. `lcd_rw` rises only after `db_oe` has already been 0 for one cycle.
- R11: If `POLL_LIMIT` status reads in a row all report busy, the block sets `timeout_err` and returns to ready. `timeout_err` stays set until the next byte is accepted, which clears it.
- R12: A byte is accepted only when `in_valid` and `in_ready` are both 1. `in_ready` is 0 from acceptance until polling ends, and no enable pulse occurs while `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode4 | input | 1 | 1 selects the four-line bus; captured with each byte |
| in_valid | input | 1 | Host offers a byte |
| in_rs | input | 1 | Register select for the offered byte |
| in_byte | input | 8 | Offered byte |
| in_ready | output | 1 | Block can accept a byte |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | Direction: 1 read, 0 write |
| lcd_e | output | 1 | Enable strobe, active high |
| db_out | output | 8 | Data bus value driven by the block |
| db_oe | output | 1 | Data bus output enable |
| db_in_msb | input | 1 | Data bus bit 7 as seen from the display |
| timeout_err | output | 1 | Busy poll gave up |

## Verification
The assertions assume three things. First, `mode4`, `in_rs` and `in_byte` matter only in the cycle a byte is accepted. Second, `db_in_msb` is meaningful only while the enable is high during a read. Third, the timing parameters leave at least one setup cycle and two tail cycles. The bench keeps to these assumptions in several ways. It changes the host inputs only between transfers. It uses a display model that drives a valid flag only 160 ns after the enable rises and drives a busy-looking value before then. Its status low nibble has bit 3 set, so a flag taken from the wrong nibble would show up. It keeps the default parameters.

// File: rtl/charlcd_busmaster.sv
module charlcd_busmaster #(
  parameter int SETUP_CYC  = 5,
  parameter int HIGH_CYC   = 18,
  parameter int LOW_CYC    = 15,
  parameter int HOLD_CYC   = 2,
  parameter int WCYCLE_CYC = 50,
  parameter int RCYCLE_CYC = 100,
  parameter int POLL_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode4,
  input  logic       in_valid,
  input  logic       in_rs,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] db_out,
  output logic       db_oe,
  input  logic       db_in_msb,
  output logic       timeout_err
);

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int W_TAIL = maxi(maxi(LOW_CYC - SETUP_CYC, WCYCLE_CYC - SETUP_CYC - HIGH_CYC), maxi(HOLD_CYC, 2));
  localparam int R_TAIL = maxi(maxi(LOW_CYC - SETUP_CYC, RCYCLE_CYC - SETUP_CYC - HIGH_CYC), maxi(HOLD_CYC, 2));
  localparam int CNT_MAX = maxi(maxi(W_TAIL, R_TAIL), maxi(SETUP_CYC, HIGH_CYC));
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_TURN, ST_SETUP, ST_HIGH, ST_TAIL} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [POLL_W-1:0] polls;
  logic             m4, rd, nib, flag;
  logic [7:0]       hold_byte;
  logic             rs_q, rw_q, e_q, oe_q, err_q;
  logic [7:0]       dout_q;
  logic [CNT_W-1:0] tail_last;

  assign tail_last   = rd ? CNT_W'(R_TAIL - 1) : CNT_W'(W_TAIL - 1);
  assign in_ready    = (st == ST_IDLE);
  assign lcd_rs      = rs_q;
  assign lcd_rw      = rw_q;
  assign lcd_e       = e_q;
  assign db_out      = dout_q;
  assign db_oe       = oe_q;
  assign timeout_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      polls     <= '0;
      m4        <= 1'b0;
      rd        <= 1'b0;
      nib       <= 1'b0;
      flag      <= 1'b0;
      hold_byte <= '0;
      rs_q      <= 1'b0;
      rw_q      <= 1'b0;
      e_q       <= 1'b0;
      oe_q      <= 1'b0;
      err_q     <= 1'b0;
      dout_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (in_valid) begin
          m4        <= mode4;
          hold_byte <= in_byte;
          rs_q      <= in_rs;
          rw_q      <= 1'b0;
          oe_q      <= 1'b1;
          dout_q    <= mode4 ? {in_byte[7:4], 4'b0000} : in_byte;
          nib       <= 1'b0;
          rd        <= 1'b0;
          err_q     <= 1'b0;
          cnt       <= '0;
          st        <= ST_SETUP;
        end
        ST_TURN: begin
          rw_q <= 1'b1;
          cnt  <= '0;
          st   <= ST_SETUP;
        end
        ST_SETUP: begin
          if (cnt == CNT_W'(SETUP_CYC - 1)) begin
            e_q <= 1'b1;
            cnt <= '0;
            st  <= ST_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt == CNT_W'(HIGH_CYC - 1)) begin
            e_q <= 1'b0;
            cnt <= '0;
            st  <= ST_TAIL;
            if (rd && !nib) flag <= db_in_msb;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (cnt == tail_last) begin
            cnt <= '0;
            if (!rd) begin
              if (m4 && !nib) begin
                nib    <= 1'b1;
                dout_q <= {hold_byte[3:0], 4'b0000};
                st     <= ST_SETUP;
              end else begin
                oe_q   <= 1'b0;
                dout_q <= '0;
                rs_q   <= 1'b0;
                rd     <= 1'b1;
                nib    <= 1'b0;
                polls  <= '0;
                st     <= ST_TURN;
              end
            end else if (m4 && !nib) begin
              nib <= 1'b1;
              st  <= ST_SETUP;
            end else if (!flag) begin
              st <= ST_IDLE;
            end else if (polls == POLL_W'(POLL_LIMIT - 1)) begin
              err_q <= 1'b1;
              st    <= ST_IDLE;
            end else begin
              polls <= polls + 1'b1;
              nib   <= 1'b0;
              st    <= ST_SETUP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

module charlcd_busmaster_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_e,
  input logic [7:0] db_out,
  input logic       db_oe,
  input logic       timeout_err
);

  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(db_oe && lcd_rw));

  a_r10_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_rw) |-> !$past(db_oe));

  a_r6_ctl_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> ($stable(lcd_rs) && $stable(lcd_rw)));

  a_r6_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |=> ($stable(lcd_rs) && $stable(lcd_rw)));

  a_r5_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && !lcd_rw) |-> $stable(db_out));

  a_r12_no_strobe_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !lcd_e);

  a_r11_err_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> in_ready);

endmodule

bind charlcd_busmaster charlcd_busmaster_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .lcd_rs(lcd_rs),
  .lcd_rw(lcd_rw), .lcd_e(lcd_e), .db_out(db_out), .db_oe(db_oe),
  .timeout_err(timeout_err)
);

// File: tb/sim_charlcd_busmaster.sv
module sim_charlcd_busmaster;
  localparam int CLK_NS = 10;
  localparam int E_HIGH_MIN = (140 + CLK_NS - 1) / CLK_NS;
  localparam int E_LOW_MIN  = (140 + CLK_NS - 1) / CLK_NS;
  localparam int CTL_SETUP  = (40 + CLK_NS - 1) / CLK_NS;
  localparam int DAT_SETUP  = (80 + CLK_NS - 1) / CLK_NS;
  localparam int HOLD_MIN   = (10 + CLK_NS - 1) / CLK_NS;
  localparam int WCYC_MIN   = 500 / CLK_NS;
  localparam int RCYC_MIN   = 1000 / CLK_NS;
  localparam int DDR_CYC    = (160 + CLK_NS - 1) / CLK_NS;
  localparam int LIMIT      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic mode4 = 0, in_valid = 0, in_rs = 0;
  logic [7:0] in_byte = '0;
  logic in_ready, lcd_rs, lcd_rw, lcd_e, db_oe, timeout_err, db_in_msb;
  logic [7:0] db_out;

  charlcd_busmaster u0 (
    .clk(clk), .rst_n(rst_n), .mode4(mode4), .in_valid(in_valid), .in_rs(in_rs),
    .in_byte(in_byte), .in_ready(in_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_e(lcd_e), .db_out(db_out), .db_oe(db_oe), .db_in_msb(db_in_msb),
    .timeout_err(timeout_err)
  );

  int checks = 0, failures = 0;
  int busy_left = 0, busy_cfg = 0;
  logic m_m4 = 0, wnib = 0, rnib = 0;
  logic [7:0] cap = '0;
  logic cap_rs = 0;
  int wr_pulses = 0, st_reads = 0;
  int busy_viol = 0, lownib_bad = 0, rd_rs1 = 0, bad_oe = 0, strobe_ready = 0;
  int contention = 0, rw_early = 0;
  int v_hi = 0, v_lo = 0, v_ctl = 0, v_dat = 0, v_hold = 0, v_wcyc = 0, v_rcyc = 0;
  int e_hi = 0, e_lo = 100, since_ctl = 100, since_dat = 100, since_fall = 0, since_rise = 0;
  logic have_rise = 0, after_fall = 0, prev_rd = 0;
  logic prev_e = 0, prev_rs = 0, prev_rw = 0, prev_oe = 0;
  logic [7:0] prev_dout = '0;

  // status register model: busy in bit 7, address 0x2A below it (low nibble bit 3 is 1)
  logic [7:0] stat;
  always_comb begin
    stat = {busy_left > 0, 7'h2A};
    if (lcd_e && lcd_rw && e_hi >= DDR_CYC)
      db_in_msb = (m_m4 && rnib) ? stat[3] : stat[7];
    else
      db_in_msb = 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_rs != prev_rs || lcd_rw != prev_rw) begin
        if (after_fall && since_fall + 1 < HOLD_MIN) v_hold++;
        since_ctl = 0;
      end else since_ctl++;
      if (db_out != prev_dout) begin
        if (lcd_e) v_dat++;
        if (after_fall && !prev_rd && since_fall + 1 < HOLD_MIN) v_hold++;
        since_dat = 0;
      end else since_dat++;
      since_fall++;
      since_rise++;
      if (db_oe && lcd_rw) contention++;
      if (lcd_rw && !prev_rw && prev_oe) rw_early++;
      if (lcd_e && in_ready) strobe_ready++;
      if (lcd_e && !prev_e) begin
        if (since_ctl < CTL_SETUP) v_ctl++;
        if (e_lo < E_LOW_MIN) v_lo++;
        if (have_rise) begin
          if (prev_rd && since_rise < RCYC_MIN) v_rcyc++;
          if (!prev_rd && since_rise < WCYC_MIN) v_wcyc++;
        end
        have_rise = 1; since_rise = 0; after_fall = 0; e_hi = 1;
      end else if (lcd_e) e_hi++;
      if (!lcd_e && prev_e) begin
        if (e_hi < E_HIGH_MIN) v_hi++;
        after_fall = 1; since_fall = 0; e_lo = 1; prev_rd = lcd_rw;
        if (!lcd_rw) begin
          if (since_dat < DAT_SETUP) v_dat++;
          if (!db_oe) bad_oe++;
          if (busy_left > 0) busy_viol++;
          wr_pulses++;
          cap_rs = lcd_rs;
          if (m_m4) begin
            if (db_out[3:0] != 4'h0) lownib_bad++;
            if (!wnib) cap[7:4] = db_out[7:4];
            else begin cap[3:0] = db_out[7:4]; busy_left = busy_cfg; end
            wnib = ~wnib;
          end else begin
            cap = db_out; busy_left = busy_cfg;
          end
        end else begin
          if (lcd_rs) rd_rs1++;
          if (!m_m4 || rnib) begin
            st_reads++;
            if (busy_left > 0) busy_left--;
          end
          if (m_m4) rnib = ~rnib;
        end
      end else if (!lcd_e) e_lo++;
    end
    prev_e = lcd_e; prev_rs = lcd_rs; prev_rw = lcd_rw; prev_oe = db_oe; prev_dout = db_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic rdy_after;
  task automatic xfer(input logic m4, input logic rs, input logic [7:0] b, input int busy);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    wr_pulses = 0; st_reads = 0; m_m4 = m4; busy_cfg = busy; wnib = 0; rnib = 0;
    mode4 = m4; in_rs = rs; in_byte = b; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    rdy_after = in_ready;
    for (int n = 0; n < 20000 && !in_ready; n++) @(negedge clk);
  endtask

  // {mode4, rs, byte, busy polls}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 1'b0, 8'h01, 6'd0},
    {1'b0, 1'b1, 8'h41, 6'd3},
    {1'b1, 1'b0, 8'h28, 6'd2},
    {1'b1, 1'b1, 8'hA5, 6'd0},
    {1'b0, 1'b1, 8'hFF, 6'd5},
    {1'b1, 1'b1, 8'h3C, 6'd7},
    {1'b0, 1'b0, 8'h80, 6'd1},
    {1'b1, 1'b0, 8'h0F, 6'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(lcd_e == 0 && db_oe == 0, "R1 in reset e/oe", {lcd_e, db_oe}, 0);
    chk(in_ready == 1 && timeout_err == 0, "R1 in reset ready/err", {in_ready, timeout_err}, 2);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(lcd_e == 0 && in_ready == 1 && timeout_err == 0, "R1 after release", {lcd_e, in_ready, timeout_err}, 2);

    for (int i = 0; i < 8; i++) begin
      logic m; logic r; logic [7:0] b; int bz;
      m = VEC[i][15]; r = VEC[i][14]; b = VEC[i][13:6]; bz = int'(VEC[i][5:0]);
      xfer(m, r, b, bz);
      chk(cap == b, m ? "R4 byte" : "R3 byte", cap, b);
      chk(wr_pulses == (m ? 2 : 1), m ? "R4 pulses" : "R3 pulses", wr_pulses, m ? 2 : 1);
      chk(cap_rs == r, "R2 rs", cap_rs, r);
      chk(st_reads == bz + 1, m ? "R9 status reads" : "R8 status reads", st_reads, bz + 1);
      chk(timeout_err == 0, "R11 no error", timeout_err, 0);
      chk(rdy_after == 0, "R12 ready low after accept", rdy_after, 0);
    end

    xfer(1'b0, 1'b1, 8'h55, 20);
    chk(st_reads == LIMIT, "R11 reads before timeout", st_reads, LIMIT);
    chk(timeout_err == 1 && in_ready == 1, "R11 error raised", {timeout_err, in_ready}, 3);
    busy_left = 0;
    repeat (5) @(negedge clk);
    chk(timeout_err == 1, "R11 error held while idle", timeout_err, 1);
    xfer(1'b1, 1'b0, 8'hC3, 20);
    chk(st_reads == LIMIT, "R9 narrow timeout reads", st_reads, LIMIT);
    chk(timeout_err == 1, "R11 narrow error", timeout_err, 1);
    busy_left = 0;
    xfer(1'b0, 1'b0, 8'h06, 0);
    chk(timeout_err == 0, "R11 cleared by accept", timeout_err, 0);
    chk(cap == 8'h06, "R3 byte after timeout", cap, 8'h06);

    chk(v_hi == 0 && v_lo == 0 && v_dat == 0, "R5 widths and data setup", v_hi + v_lo + v_dat, 0);
    chk(v_ctl == 0 && v_hold == 0, "R6 control setup and hold", v_ctl + v_hold, 0);
    chk(v_wcyc == 0 && v_rcyc == 0, "R7 cycle times", v_wcyc + v_rcyc, 0);
    chk(busy_viol == 0 && rd_rs1 == 0 && bad_oe == 0, "R8 no write while busy", busy_viol + rd_rs1 + bad_oe, 0);
    chk(lownib_bad == 0, "R4 low lines zero", lownib_bad, 0);
    chk(contention == 0 && rw_early == 0, "R10 bus release", contention + rw_early, 0);
    chk(strobe_ready == 0, "R12 no strobe when ready", strobe_ready, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule